// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Receiver with Address Filter

This block receives asynchronous serial frames on a single input line and delivers the received bytes through a two-entry receive buffer. Frames are either start + 8 data bits + stop, or start + 9 data bits + stop, and are sent least significant bit first. The line is sampled once per pulse of an external baud tick that runs at 16 times the bit rate. The start bit is confirmed at mid-bit, and each bit is decided by a 2-of-3 majority vote.

A single byte-wide control/status register turns the port on, picks the frame length and enables reception. It can also switch on an address filter. When the filter is on in 9-bit mode, only frames whose ninth bit is 1 reach the buffer. Each buffer entry carries a framing-error flag and the ninth bit. The register shows these two flags for the entry at the head of the buffer.

The interrupt request stays high while the buffer holds data. When a frame completes and the buffer is full, that frame is lost and a sticky overrun flag is set. While the flag is set, reception stops. Software clears the flag by turning continuous receive off.

Top module: `uart9_rx`

## Requirements
- R1: After reset the register reads 0x00, `irq` is low, and bit 0 reads 0 while the buffer is empty.
- R2: While the port-enable bit (bit 7) is 0, no frame is received and the buffer stays empty.
- R3: With bit 6 = 0, the frame is one low start bit, 8 data bits LSB first and one stop bit. The received byte appears on `rxbuf_data`, bit 0 of the register reads 0, and `irq` is high while the buffer is not empty.
- R4: While the continuous-receive bit (bit 4) is 0, no frame is received. The single-receive bit (bit 5) can be written and read back but does not start reception.
- R5: With bit 6 = 1 and the address-detect bit (bit 3) = 1, a frame whose ninth bit is 0 is dropped and does not raise `irq`. A frame whose ninth bit is 1 is stored.
- R6: With bit 6 = 1 and bit 3 = 0, every frame is stored, and its ninth bit is reported in register bit 0.
- R7: With bit 6 = 0, the address-detect bit has no effect, and every frame is stored.
- R8: A stop bit that is sampled low sets the framing-error flag (register bit 2) of that entry. The data is stored all the same.
- R9: The buffer holds two entries. A frame that completes while both entries are full is lost and sets the overrun flag (bit 1). While the flag is set, no frame is accepted. Writing 0 to bit 4 is the only way to clear it.
- R10: Register bits 2 and 0 show the entry at the head of the buffer. A one-cycle pulse on `rxbuf_rd` removes the head, and both bits then show the next entry.
- R11: A low pulse that ends before sample 7 of a 16-sample bit is not taken as a start bit. A frame that follows such a glitch is received correctly.
- R12: Register bits 7 to 3 can be written. Writes to bits 2 to 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| reg_we | input | 1 | Write strobe for the control/status register |
| reg_wdata | input | 8 | Write data for the control/status register |
| reg_rdata | output | 8 | Control/status register read value |
| rxbuf_rd | input | 1 | Removes the head entry of the receive buffer |
| rxbuf_data | output | 8 | Data byte of the head entry |
| irq | output | 1 | Receive interrupt request, high while data is buffered |

## Verification
The bench sends 8-bit frames with varied bit patterns to show that the bit order and the frame length are decoded correctly. It then sends 9-bit frames with the ninth bit set and clear, once with the address filter on and once with it off. This separates filtering from plain ninth-bit reporting. It also sends the same filter setting with 8-bit frames, to show that the setting is ignored there. Further stimulus covers stop bits held low, buffered entries read one at a time so the head flags can be followed, a burst of frames that overflows the buffer, a short start glitch, and frames sent while the port or continuous receive is off.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    localparam int DATA_W   = 8;
    localparam int OSR      = 16;
    localparam int CTL_W    = 5;

    typedef struct packed {
        logic port_en;
        logic nine;
        logic single;
        logic cont;
        logic addr_det;
    } ctl_t;

    typedef struct packed {
        logic              ferr;
        logic              bit9;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    function automatic logic maj3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/uart9_line_sync.sv
module uart9_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) ff[0] <= 1'b1;
                    else     ff[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) ff[g] <= 1'b1;
                    else     ff[g] <= ff[g-1];
                end
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/uart9_rx_core.sv
module uart9_rx_core
    import uart9_pkg::*;
#(
    parameter int OSR_P = OSR
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      tick,
    input  logic      line,
    input  logic      nine,
    output logic      done,
    output rx_entry_t frame
);
    localparam int CW    = $clog2(OSR_P);
    localparam int VOTE0 = OSR_P / 2 - 1;
    localparam int LAST  = OSR_P - 1;
    localparam int STOPD = VOTE0 + 3;

    rx_state_e     state;
    logic [CW-1:0] sc;
    logic [2:0]    votes;
    logic [3:0]    idx;
    logic [8:0]    sh;
    logic          vote_now;
    logic          bit_v;
    logic [3:0]    last_idx;

    assign vote_now = (sc >= CW'(VOTE0)) && (sc <= CW'(VOTE0 + 2));
    assign bit_v    = maj3(votes);
    assign last_idx = nine ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst || !enable) begin
            state <= RX_IDLE;
            sc    <= '0;
            votes <= 3'b111;
            idx   <= '0;
            sh    <= '0;
            if (rst) frame <= '0;
        end else if (tick) begin
            if (vote_now) votes <= {votes[1:0], line};
            unique case (state)
                RX_IDLE: begin
                    if (!line) begin
                        state <= RX_START;
                        sc    <= CW'(1);
                        sh    <= '0;
                    end
                end
                RX_START: begin
                    sc <= sc + 1'b1;
                    if (sc == CW'(LAST)) begin
                        sc <= '0;
                        if (!bit_v) begin
                            state <= RX_DATA;
                            idx   <= '0;
                        end else begin
                            state <= RX_IDLE;
                        end
                    end
                end
                RX_DATA: begin
                    sc <= sc + 1'b1;
                    if (sc == CW'(LAST)) begin
                        sc      <= '0;
                        sh[idx] <= bit_v;
                        if (idx == last_idx) state <= RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_STOP: begin
                    sc <= sc + 1'b1;
                    if (sc == CW'(STOPD)) begin
                        state      <= RX_IDLE;
                        sc         <= '0;
                        done       <= 1'b1;
                        frame.ferr <= ~bit_v;
                        frame.bit9 <= nine & sh[8];
                        frame.data <= sh[7:0];
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assert_off_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == RX_IDLE && !done));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/uart9_rx_fifo.sv
module uart9_rx_fifo
    import uart9_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  rx_entry_t                  wr_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic            do_pop;
    logic            do_push;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != CNW'(DEPTH)) || do_pop);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= wr_entry;
                wp      <= nxt(wp);
            end
            if (do_pop) rp <= nxt(rp);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assign head = (count == '0) ? '0 : mem[rp];

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        count <= CNW'(DEPTH));

    assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
        (push && count == CNW'(DEPTH) && !pop) |=> count == CNW'(DEPTH));

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2,
    parameter int OSR_P       = OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              baud_tick,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rxbuf_rd,
    output logic [DATA_W-1:0] rxbuf_data,
    output logic              irq
);
    localparam int CNW = $clog2(DEPTH + 1);

    ctl_t            ctl;
    logic            ovr;
    logic            line_s;
    logic            rx_en;
    logic            done;
    rx_entry_t       frame;
    rx_entry_t       head;
    logic [CNW-1:0]  count;
    logic            accept;
    logic            full;
    logic            pop;
    logic            push;

    uart9_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rx_line),
        .q   (line_s)
    );

    assign rx_en = ctl.port_en && ctl.cont && !ovr;

    uart9_rx_core #(.OSR_P(OSR_P)) u_core (
        .clk    (clk),
        .rst    (rst),
        .enable (rx_en),
        .tick   (baud_tick),
        .line   (line_s),
        .nine   (ctl.nine),
        .done   (done),
        .frame  (frame)
    );

    assign accept = done && (!(ctl.nine && ctl.addr_det) || frame.bit9);
    assign full   = (count == CNW'(DEPTH));
    assign pop    = rxbuf_rd;
    assign push   = accept && (!full || pop);

    uart9_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .wr_entry (frame),
        .pop      (pop),
        .head     (head),
        .count    (count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            ovr <= 1'b0;
        end else begin
            if (reg_we) ctl <= ctl_t'(reg_wdata[7:8-CTL_W]);
            if (!ctl.cont)                      ovr <= 1'b0;
            else if (accept && full && !pop)    ovr <= 1'b1;
        end
    end

    assign reg_rdata  = {ctl, head.ferr, ovr, head.bit9};
    assign rxbuf_data = head.data;
    assign irq        = (count != '0);

    assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ovr && ctl.cont) |=> ovr);

    assert_addr_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (done && ctl.nine && ctl.addr_det && !frame.bit9) |=> (count <= $past(count)));

    assert_ovr_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        ovr |=> !done);

endmodule

// File: tb/uart9_rx_bench.sv
module uart9_rx_bench;
    localparam int TDIV = 4;
    localparam int BITC = 16 * TDIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       mon_rd = 1'b0;
    logic       man_rd = 1'b0;
    logic       rxbuf_rd;
    logic [7:0] rxbuf_data;
    logic       irq;
    logic       auto_read = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int tcnt     = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    assign rxbuf_rd = mon_rd | man_rd;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tcnt      <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
        baud_tick <= (tcnt == 0);
    end

    uart9_rx u_uart9_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_line    (rx_line),
        .baud_tick  (baud_tick),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .rxbuf_rd   (rxbuf_rd),
        .rxbuf_data (rxbuf_data),
        .irq        (irq)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic use9,
                        input logic stop_hi, input logic expect_it, input string tag);
        if (expect_it) begin
            exp_q.push_back({~stop_hi, use9 & b9, d});
            tag_q.push_back(tag);
        end
        rx_line = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            repeat (BITC) @(negedge clk);
        end
        if (use9) begin
            rx_line = b9;
            repeat (BITC) @(negedge clk);
        end
        rx_line = stop_hi;
        repeat (BITC) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BITC) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        repeat (100) @(negedge clk);
        check(exp_q.size() == 0, tag, "pending expected frames", exp_q.size(), 0);
        check(irq == 1'b0, tag, "irq after drain", irq, 0);
    endtask

    task automatic head_check(input logic [9:0] expv, input string tag);
        @(negedge clk);
        check({reg_rdata[2], reg_rdata[0], rxbuf_data} == expv, tag, "head entry",
              {reg_rdata[2], reg_rdata[0], rxbuf_data}, expv);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    // Scoreboard monitor
    always begin
        @(negedge clk);
        if (auto_read && irq) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected frame", rxbuf_data, 0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({reg_rdata[2], reg_rdata[0], rxbuf_data} == e, t, "received entry",
                      {reg_rdata[2], reg_rdata[0], rxbuf_data}, e);
            end
            mon_rd = 1'b1;
            @(negedge clk);
            mon_rd = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 8'h00, "R1", "reg after reset", reg_rdata, 8'h00);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);

        // R2 port disabled: continuous on, port off
        auto_read = 1'b1;
        wr(8'h10);
        send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
        drain("R2");

        // R4 continuous off, single set; R12 low bits not writable
        wr(8'hA7);
        check(reg_rdata == 8'hA0, "R12", "read-only bits ignored", reg_rdata, 8'hA0);
        send(8'h33, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        drain("R4");
        check(reg_rdata == 8'hA0, "R4", "single bit readback", reg_rdata, 8'hA0);

        // R3 8-bit frames
        wr(8'h90);
        send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        send(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        send(8'h01, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        drain("R3");

        // R11 short start glitch then a good frame
        rx_line = 1'b0;
        repeat (5 * TDIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (2 * BITC) @(negedge clk);
        drain("R11");
        send(8'hC3, 1'b0, 1'b0, 1'b1, 1'b1, "R11");
        drain("R11");

        // R6 9-bit, no address filter
        wr(8'hD0);
        send(8'h12, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        send(8'h34, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
        drain("R6");

        // R5 9-bit with address filter
        wr(8'hD8);
        send(8'h56, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        send(8'h78, 1'b1, 1'b1, 1'b1, 1'b1, "R5");
        send(8'h9A, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
        drain("R5");

        // R7 address filter ignored in 8-bit mode
        wr(8'h98);
        send(8'hE7, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        drain("R7");

        // R8 / R10 head-following flags, manual reads
        auto_read = 1'b0;
        wr(8'hD0);
        send(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        send(8'h22, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        head_check({1'b1, 1'b1, 8'h11}, "R8");
        head_check({1'b0, 1'b0, 8'h22}, "R10");
        @(negedge clk);
        check(irq == 1'b0, "R10", "irq after reads", irq, 0);

        // R9 overrun
        wr(8'h90);
        send(8'hA1, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        send(8'hA2, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        check(reg_rdata[1] == 1'b0, "R9", "no overrun with two", reg_rdata[1], 0);
        send(8'hA3, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        check(reg_rdata[1] == 1'b1, "R9", "overrun set", reg_rdata[1], 1);
        head_check({2'b00, 8'hA1}, "R9");
        send(8'hA4, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
        head_check({2'b00, 8'hA2}, "R9");
        @(negedge clk);
        check(irq == 1'b0, "R9", "frames blocked during overrun", irq, 0);
        wr(8'h90);
        check(reg_rdata[1] == 1'b1, "R9", "overrun kept on rewrite", reg_rdata[1], 1);
        wr(8'h80);
        check(reg_rdata[1] == 1'b0, "R9", "overrun cleared", reg_rdata[1], 0);
        auto_read = 1'b1;
        wr(8'h90);
        send(8'h5F, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        drain("R9");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule